// File: doc/BRIEF.md
# Auto-Incrementing Colour Palette Lookup

This block holds a 256-entry colour table and turns a stream of pixel words into 8-bit red, green and blue values. Software loads it through one write port. Each bus word carries a register selector in its top nibble and a value in its low bits, so one store both names the target and supplies the data. One selector clears the internal write index. Another stores a 24-bit colour at the current index and then steps the index forward. A third selector loads the bits-per-pixel code.

On the pixel side, pixels enter through a valid/ready stream and leave one stage later on a valid/ready stream. Back-pressure works as follows. A pixel is taken only in a cycle where `pix_ready` is high. `pix_ready` is high when the output slot is empty or when the slot is being drained in that same cycle. While `out_valid` is high and `out_ready` is low, the colour outputs hold their values. The write port has no ready signal and accepts every word on which `wr_valid` is high.

There are three ways to read the table. In the direct modes (1, 2, 4 and 8 bpp), the low bits of the pixel select one entry and all three channels come from it. In the 16-bpp mode, each channel reads its own entry, taken from three overlapping byte slices of the pixel. In the 32-bpp mode, each pixel byte indexes its own channel, which acts as a per-channel gamma table.

Top module: `pal_lut`

## Requirements
- R1: After reset, `out_valid` is 0, `pix_ready` is 1, the write index is 0 and the pixel mode code is 3 (8 bpp). Table contents are undefined until they are written.
- R2: A bus word carries its selector in bits [31:28] and its value in the bits below. Selector 1 is index-clear, selector 2 is colour-write and selector 3 is mode-load. Words with any other selector change neither the index, the table nor the mode.
- R3: A selector-1 write sets the write index to 0, whatever its value bits hold.
- R4: A selector-2 write stores value bits [23:0] at the current index and then increments the index. Within an entry, red is [7:0], green is [15:8] and blue is [23:16].
- R5: The index wraps modulo 256, so the write that follows one to entry 255 lands in entry 0.
- R6: A selector-3 write loads the mode code from value bits [7:5]. Codes 0, 1, 2, 3, 4 and 6 select 1, 2, 4, 8, 16 and 32 bpp, and codes 5 and 7 behave as 8 bpp. The new code applies to pixels accepted from the next cycle on.
- R7: In the direct modes with code c, the entry index is the pixel's low 2^c bits, zero-extended, and red, green and blue all come from that one entry.
- R8: At 16 bpp, red is read from the entry at pixel[7:0], green from the entry at pixel[11:4] and blue from the entry at pixel[15:8].
- R9: At 32 bpp, red is read from the red channel of the entry at pixel[7:0], green from the green channel of the entry at pixel[15:8], and blue from the blue channel of the entry at pixel[23:16].
- R10: A pixel accepted in cycle t appears with `out_valid` in cycle t+1. A colour write to an entry that a pixel reads in the same cycle returns the entry's old value.
- R11: `pix_ready` equals (not `out_valid`) or `out_ready`. While `out_valid` is high and `out_ready` is low, the valid flag and the colour outputs stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Bus word present this cycle |
| wr_word | input | 32 | Selector in [31:28], value below |
| pix_valid | input | 1 | Pixel word offered |
| pix_ready | output | 1 | Pixel word taken this cycle when also valid |
| pix_data | input | 24 | Pixel word |
| out_valid | output | 1 | Colour result present |
| out_ready | input | 1 | Downstream takes the result |
| out_red | output | 8 | Red channel |
| out_green | output | 8 | Green channel |
| out_blue | output | 8 | Blue channel |

## Verification
The bench loads the whole table, then writes two more colours. A counter that saturated or reset at 255 would leave entries 0 and 1 holding their first contents. Each direct mode gets pixels with junk in the high bits, so a missing mask would read the wrong entry. The 16-bpp and 32-bpp modes are checked against entries whose channels all differ, which exposes swapped or non-overlapping slices. The bench also issues a same-cycle write and read of one entry, where a bypassing design would return the new colour early. It sends an unknown selector, which a loose decoder would turn into a store or an index step. Random stalls on `out_ready` catch outputs that move, or pixels that are lost or duplicated, while the output slot is blocked.

// File: rtl/pal_lut_pkg.sv
package pal_lut_pkg;
  localparam int SEL_W = 4;

  // Register selectors, carried in the top nibble of every bus word
  typedef enum logic [SEL_W-1:0] {
    SEL_IDX_CLR = 4'h1,
    SEL_COLOUR  = 4'h2,
    SEL_MODE    = 4'h3
  } pal_sel_e;

  // Bits-per-pixel codes
  typedef enum logic [2:0] {
    BPP_1  = 3'd0,
    BPP_2  = 3'd1,
    BPP_4  = 3'd2,
    BPP_8  = 3'd3,
    BPP_16 = 3'd4,
    BPP_32 = 3'd6
  } bpp_code_e;

  localparam logic [2:0] MODE_RESET = 3'd3;
endpackage

// File: rtl/pal_wr_decode.sv
module pal_wr_decode
  import pal_lut_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int IDX_W    = 8,
  parameter int ENT_W    = 24,
  parameter int MODE_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  output logic              ent_we,
  output logic [IDX_W-1:0]  ent_addr,
  output logic [ENT_W-1:0]  ent_data,
  output logic [2:0]        mode_code
);
  localparam int SEL_LSB = WORD_W - SEL_W;

  logic [SEL_W-1:0] sel;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       mode_q;

  assign sel = wr_word[SEL_LSB +: SEL_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q  <= '0;
      mode_q <= MODE_RESET;
    end else if (wr_valid) begin
      case (sel)
        SEL_IDX_CLR: idx_q  <= '0;
        SEL_COLOUR:  idx_q  <= idx_q + 1'b1;
        SEL_MODE:    mode_q <= wr_word[MODE_LSB +: 3];
        default:     ;
      endcase
    end
  end

  assign ent_we    = wr_valid && (sel == SEL_COLOUR);
  assign ent_addr  = idx_q;
  assign ent_data  = wr_word[ENT_W-1:0];
  assign mode_code = mode_q;
endmodule

// File: rtl/pal_addr_gen.sv
module pal_addr_gen
  import pal_lut_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int NCH   = 3
) (
  input  logic [2:0]                 mode_code,
  input  logic [NCH*IDX_W-1:0]       pix,
  output logic [NCH-1:0][IDX_W-1:0]  addr
);
  localparam int HALF = IDX_W / 2;

  function automatic logic [IDX_W-1:0] direct_mask(input logic [2:0] code);
    logic [IDX_W-1:0] m;
    m = '0;
    for (int b = 0; b < IDX_W; b++)
      if (b < (1 << code)) m[b] = 1'b1;
    return m;
  endfunction

  always_comb begin
    for (int ch = 0; ch < NCH; ch++) begin
      case (mode_code)
        BPP_1, BPP_2, BPP_4:
          addr[ch] = pix[IDX_W-1:0] & direct_mask(mode_code);
        BPP_16:
          addr[ch] = pix[ch*HALF +: IDX_W];
        BPP_32:
          addr[ch] = pix[ch*IDX_W +: IDX_W];
        default:
          addr[ch] = pix[IDX_W-1:0];
      endcase
    end
  end
endmodule

// File: rtl/pal_chan_ram.sv
module pal_chan_ram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Read sees the pre-write contents on an address collision
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/pal_lut.sv
module pal_lut
  import pal_lut_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CH_W     = 8,
  parameter int MODE_LSB = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [3*CH_W-1:0] pix_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CH_W-1:0]   out_red,
  output logic [CH_W-1:0]   out_green,
  output logic [CH_W-1:0]   out_blue
);
  localparam int NCH   = 3;
  localparam int IDX_W = CH_W;
  localparam int ENT_W = NCH * CH_W;

  logic                       ent_we;
  logic [IDX_W-1:0]           wr_idx;
  logic [ENT_W-1:0]           ent_data;
  logic [2:0]                 mode_code;
  logic [NCH-1:0][IDX_W-1:0]  rd_addr;
  logic [NCH-1:0][CH_W-1:0]   rd_data;
  logic                       accept;
  logic                       valid_q;

  pal_wr_decode #(
    .WORD_W(WORD_W), .IDX_W(IDX_W), .ENT_W(ENT_W), .MODE_LSB(MODE_LSB)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .ent_we(ent_we), .ent_addr(wr_idx), .ent_data(ent_data),
    .mode_code(mode_code)
  );

  pal_addr_gen #(.IDX_W(IDX_W), .NCH(NCH)) u_addr (
    .mode_code(mode_code), .pix(pix_data), .addr(rd_addr)
  );

  assign pix_ready = !valid_q || out_ready;
  assign accept    = pix_valid && pix_ready;

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    pal_chan_ram #(.ADDR_W(IDX_W), .DATA_W(CH_W)) u_ram (
      .clk(clk), .we(ent_we), .waddr(wr_idx),
      .wdata(ent_data[ch*CH_W +: CH_W]),
      .re(accept), .raddr(rd_addr[ch]), .rdata(rd_data[ch])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         valid_q <= 1'b0;
    else if (accept)    valid_q <= 1'b1;
    else if (out_ready) valid_q <= 1'b0;
  end

  assign out_valid = valid_q;
  assign out_red   = rd_data[0];
  assign out_green = rd_data[1];
  assign out_blue  = rd_data[2];
endmodule

// File: rtl/pal_lut_checker.sv
module pal_lut_checker
  import pal_lut_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int CH_W   = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [WORD_W-1:0] wr_word,
  input logic              pix_valid,
  input logic              pix_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [CH_W-1:0]   out_red,
  input logic [CH_W-1:0]   out_green,
  input logic [CH_W-1:0]   out_blue,
  input logic [CH_W-1:0]   idx,
  input logic [2:0]        mode
);
  logic [SEL_W-1:0] sel;
  logic             is_clr, is_col, is_mode;
  assign sel     = wr_word[WORD_W-1 -: SEL_W];
  assign is_clr  = wr_valid && sel == SEL_IDX_CLR;
  assign is_col  = wr_valid && sel == SEL_COLOUR;
  assign is_mode = wr_valid && sel == SEL_MODE;

  AST_IDX_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    is_clr |=> idx == '0); // R3
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |=> idx == CH_W'($past(idx) + 1'b1)); // R5
  AST_IDX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(is_clr || is_col) |=> $stable(idx)); // R2
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !is_mode |=> $stable(mode)); // R6
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_red, out_green, out_blue})); // R11
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !pix_ready); // R11
endmodule

bind pal_lut pal_lut_checker #(.WORD_W(WORD_W), .CH_W(CH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
  .pix_valid(pix_valid), .pix_ready(pix_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_red(out_red), .out_green(out_green),
  .out_blue(out_blue), .idx(wr_idx), .mode(mode_code)
);

// File: tb/tb_pal_lut.sv
module tb_pal_lut;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_word = '0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [23:0] pix_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_red, out_green, out_blue;

  pal_lut dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_word(wr_word),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_red(out_red),
    .out_green(out_green), .out_blue(out_blue)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string tag = "R1";

  // Behavioural reference state
  logic [23:0] m_mem [256];
  int          m_idx = 0;
  int          m_mode = 3;
  bit          e_valid = 1'b0;
  logic [23:0] e_rgb = '0;

  // Next-cycle stimulus
  bit          n_wr = 1'b0;
  logic [31:0] n_word = '0;
  bit          n_pix = 1'b0;
  logic [23:0] n_pdata = '0;
  bit          n_ordy = 1'b1;

  function automatic logic [23:0] entry_pat(int i);
    return {8'(i * 7 + 3), 8'(~i), 8'(i ^ 8'h5A)};
  endfunction

  function automatic logic [23:0] lookup(int mode, logic [23:0] p);
    int a;
    case (mode)
      0, 1, 2: begin
        a = int'(p[7:0]) % (1 << (1 << mode));
        return m_mem[a];
      end
      4: return {m_mem[p[15:8]][23:16], m_mem[p[11:4]][15:8], m_mem[p[7:0]][7:0]};
      6: return {m_mem[p[23:16]][23:16], m_mem[p[15:8]][15:8], m_mem[p[7:0]][7:0]};
      default: return m_mem[p[7:0]];
    endcase
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // One clock: compare at the falling edge, then drive and advance the model
  task automatic cycle();
    bit acc;
    @(negedge clk);
    check(out_valid === e_valid, tag, "out_valid", 32'(out_valid), 32'(e_valid));
    check(pix_ready === (!e_valid || out_ready), "R11", "pix_ready",
          32'(pix_ready), 32'(!e_valid || out_ready));
    if (e_valid)
      check({out_blue, out_green, out_red} === e_rgb, tag, "rgb",
            32'({out_blue, out_green, out_red}), 32'(e_rgb));
    wr_valid  = n_wr;
    wr_word   = n_word;
    pix_valid = n_pix;
    pix_data  = n_pdata;
    out_ready = n_ordy;
    acc = n_pix && (!e_valid || n_ordy);
    if (acc) begin
      e_valid = 1'b1;
      e_rgb   = lookup(m_mode, n_pdata);
    end else if (n_ordy) begin
      e_valid = 1'b0;
    end
    if (n_wr) begin
      case (n_word[31:28])
        4'h1: m_idx = 0;
        4'h2: begin m_mem[m_idx] = n_word[23:0]; m_idx = (m_idx + 1) % 256; end
        4'h3: m_mode = int'(n_word[7:5]);
        default: ;
      endcase
    end
    n_wr  = 1'b0;
    n_pix = 1'b0;
  endtask

  task automatic wr(logic [3:0] sel, logic [27:0] val);
    n_wr = 1'b1; n_word = {sel, val};
  endtask

  task automatic px(logic [23:0] d);
    n_pix = 1'b1; n_pdata = d;
  endtask

  task automatic set_mode(int code);
    wr(4'h3, 28'(code << 5) | 28'h100_001F); cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state observed at the ports
    tag = "R1";
    cycle();

    // R3/R4: clear index (junk value bits), fill the whole table
    tag = "R4";
    wr(4'h1, 28'hFFF_FFFF); cycle();
    for (int i = 0; i < 256; i++) begin wr(4'h2, 28'(entry_pat(i))); cycle(); end
    // R1: default mode is 8 bpp
    tag = "R1";
    px(24'hABCD12); cycle();
    px(24'h0000FF); cycle();
    tag = "R7";
    for (int i = 0; i < 16; i++) begin px(24'(i * 37 + 24'h123400)); cycle(); end

    // R5: two more colours wrap onto entries 0 and 1
    tag = "R5";
    wr(4'h2, 28'h0AABBCC); cycle();
    wr(4'h2, 28'h0112233); cycle();
    px(24'h000000); cycle();
    px(24'h000001); cycle();
    px(24'h000002); cycle();

    // R3: index clear mid-stream sends the next write to entry 0
    tag = "R3";
    wr(4'h1, 28'h0000055); cycle();
    wr(4'h2, 28'h0C0FFEE); cycle();
    px(24'h000000); cycle();
    px(24'h000001); cycle();

    // R2: unknown selectors touch nothing; next colour lands in entry 1
    tag = "R2";
    wr(4'h7, 28'h0123456); cycle();
    wr(4'hF, 28'h0FFFFFF); cycle();
    wr(4'h0, 28'h0000060); cycle();
    px(24'h000001); cycle();
    wr(4'h2, 28'h0D1E2F3); cycle();
    px(24'h000001); cycle();
    px(24'h000002); cycle();
    px(24'h0000C3); cycle();

    // R6/R7: direct modes with junk in the high pixel bits
    for (int c = 0; c < 3; c++) begin
      tag = "R6";
      set_mode(c);
      tag = "R7";
      for (int i = 0; i < 10; i++) begin px(24'(i * 29 + 24'hF0F0F0)); cycle(); end
    end

    // R8: 16 bpp overlapping slices
    tag = "R6";
    set_mode(4);
    tag = "R8";
    px(24'h00F00F); cycle();
    px(24'hFF1234); cycle();
    for (int i = 0; i < 12; i++) begin px(24'($urandom)); cycle(); end

    // R9: 32 bpp per-channel
    tag = "R6";
    set_mode(6);
    tag = "R9";
    px(24'h030201); cycle();
    for (int i = 0; i < 12; i++) begin px(24'($urandom)); cycle(); end

    // R6: reserved codes act as 8 bpp; mode takes effect next cycle
    tag = "R6";
    set_mode(5);
    px(24'h77_66_55); cycle();
    set_mode(7);
    px(24'h11_22_EE); cycle();
    wr(4'h3, 28'(2 << 5)); px(24'h0000FE); cycle();
    px(24'h0000FE); cycle();
    set_mode(3);

    // R10: same-cycle write and read of one entry returns the old value
    tag = "R10";
    wr(4'h1, 28'h0); cycle();
    wr(4'h2, 28'h0555555); px(24'h000000); cycle();
    px(24'h000000); cycle();
    wr(4'h2, 28'h0AAAAAA); px(24'h000001); cycle();
    px(24'h000001); cycle();
    cycle();

    // R11: random back-pressure across modes
    tag = "R11";
    for (int i = 0; i < 400; i++) begin
      n_ordy = ($urandom % 3) != 0;
      if (($urandom % 4) != 0) px(24'($urandom));
      if (i % 100 == 50) wr(4'h3, 28'(($urandom % 8) << 5));
      if (($urandom % 7) == 0) wr(4'h2, 28'($urandom));
      cycle();
    end
    n_ordy = 1'b1;
    cycle();
    cycle();
    summary();
  end
endmodule